// File: doc/BRIEF.md
# Pad Event and Interrupt Unit

This unit watches a group of general-purpose input pads, up to 32 of them. Each pad passes through a two-stage synchroniser. A per-pad setting then turns its input into events: a level, a single edge, either edge, or nothing. A per-pad inversion bit applied before detection selects the polarity. Detected events latch into an interrupt status register and a wake status register. Software clears both by writing ones. Enable registers gate the status into one combined interrupt line and one combined wake line.

Host ownership is given per pad by an input vector. Only pads owned by the host can raise interrupt status. Wake status records events on any implemented pad. The wake line ignores pads whose events are steered to the system-control path. All registers sit on a simple 32-bit write bus with a combinational read port.

Top module: `pad_event_ctrl`

## Requirements
- R1: After reset, the interrupt status, interrupt enable, wake status and wake enable registers read zero. Every pad's event setting reads 2 (disabled). `irq` and `wake` are low.
- R2: In level mode (code 0), a pad's interrupt status bit is set on each cycle its synchronised input is at the active level. The active level is high, or low when inversion is set.
- R3: In single-edge mode (code 1), a rising edge of the input sets the status bit and a falling edge does not. With inversion set, only a falling edge sets the bit.
- R4: In both-edge mode (code 3), a rising edge and a falling edge each set the status bit.
- R5: In disabled mode (code 2), pad activity never sets any status bit.
- R6: Writing to the interrupt status register (offset 0x00) clears each bit written as 1 and leaves the bits written as 0 unchanged. If an event arrives in the same cycle, the set wins, so a persisting level keeps its bit set.
- R7: `irq` is the OR of status bits whose enable bit (offset 0x04) is set. Status bits of disabled pads stay pending without driving `irq`.
- R8: A pad whose `host_own` bit is clear never sets its interrupt status bit.
- R9: Wake status (offset 0x08, write 1 to clear) records detected events of any pad, whatever its ownership. `wake` is high while some pad has wake status and wake enable (offset 0x0C) set and its `sysctl_route` bit clear.
- R10: Bits at and above NUM_PADS in the four group registers never set and read zero. Event-setting addresses of pads beyond NUM_PADS read zero.
- R11: Pad i's event setting sits at offset 0x10 + 4*i, with the mode code in bits [1:0] and inversion in bit 2. The other bits are not stored and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NUM_PADS | Raw pad inputs, asynchronous |
| host_own | input | NUM_PADS | 1 = pad owned by the host and allowed to raise interrupt status |
| sysctl_route | input | NUM_PADS | 1 = pad events steered to the system-control path, excluded from `wake` |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Combined wake |

## Verification
A wrong mode decode or a wrong synchroniser depth shows as a status bit that is missing, extra or late. Such a bit is visible on the status read three clock edges after the pad changes. A broken clear path shows on the read directly after the write, and `irq` or `wake` follow a changed status or enable bit within the same cycle. Ownership and routing faults are caught by pairing each pad event with its interrupt status and its wake status. The two registers are set by the same event but are gated differently, so a fault shows as a mismatch between them.

// File: rtl/pad_event_ctrl.sv
module pad_event_ctrl #(
  parameter int NUM_PADS = 24,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [NUM_PADS-1:0] host_own,
  input  logic [NUM_PADS-1:0] sysctl_route,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              wake
);
  localparam int CFG_BASE = 16;
  localparam logic [31:0] PAD_MASK =
    (NUM_PADS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_PADS) - 32'd1);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WSTS = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(12);

  logic [NUM_PADS-1:0] sy1, sy2, sy3;
  logic [2:0]  cfg_q [NUM_PADS];
  logic [31:0] int_sts, int_en, wk_sts, wk_en;
  logic [31:0] evt, off_v, int_set, wk_set;
  logic [31:0] wmask;

  assign wmask = bus_wdata & PAD_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= pad_in; sy2 <= sy1; sy3 <= sy2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_PADS; i++) cfg_q[i] <= 3'b010;
    end else if (bus_we) begin
      for (int i = 0; i < NUM_PADS; i++)
        if (bus_addr == ADDR_W'(CFG_BASE + 4 * i)) cfg_q[i] <= bus_wdata[2:0];
    end

  always_comb begin
    evt   = '0;
    off_v = '0;
    for (int i = 0; i < NUM_PADS; i++) begin
      logic rx, rp;
      rx = sy2[i] ^ cfg_q[i][2];
      rp = sy3[i] ^ cfg_q[i][2];
      case (cfg_q[i][1:0])
        2'd0:    evt[i] = rx;
        2'd1:    evt[i] = rx & ~rp;
        2'd3:    evt[i] = rx ^ rp;
        default: evt[i] = 1'b0;
      endcase
      off_v[i] = (cfg_q[i][1:0] == 2'd2);
    end
  end

  assign int_set = evt & 32'(host_own);
  assign wk_set  = evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      int_sts <= '0; int_en <= '0; wk_sts <= '0; wk_en <= '0;
    end else begin
      int_sts <= (int_sts & ~((bus_we && bus_addr == A_STS)  ? wmask : 32'd0)) | int_set;
      wk_sts  <= (wk_sts  & ~((bus_we && bus_addr == A_WSTS) ? wmask : 32'd0)) | wk_set;
      if (bus_we && bus_addr == A_EN)  int_en <= wmask;
      if (bus_we && bus_addr == A_WEN) wk_en  <= wmask;
    end

  assign irq  = |(int_sts & int_en);
  assign wake = |(wk_sts & wk_en & ~32'(sysctl_route));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STS:   bus_rdata = int_sts;
      A_EN:    bus_rdata = int_en;
      A_WSTS:  bus_rdata = wk_sts;
      A_WEN:   bus_rdata = wk_en;
      default:
        for (int i = 0; i < NUM_PADS; i++)
          if (bus_addr == ADDR_W'(CFG_BASE + 4 * i)) bus_rdata = {29'd0, cfg_q[i]};
    endcase
  end

  // R8: a newly set interrupt bit needs host ownership in the cycle before
  p_owned_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_sts & ~$past(int_sts) & ~$past(32'(host_own))) == 32'd0));

  // R5: a pad in disabled mode never produces a new status bit
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_sts & ~$past(int_sts) & $past(off_v)) == 32'd0));

  // R6: bits written as one clear unless an event sets them in that cycle
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STS) |=>
      ((int_sts & $past(bus_wdata) & ~$past(int_set)) == 32'd0));

  // R7: the interrupt can only drop after a bus write
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_we));

  // R10: bits beyond the last pad stay clear in every group register
  p_tail_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((int_sts | int_en | wk_sts | wk_en) & ~PAD_MASK) == 32'd0));
endmodule

// File: tb/pad_event_ctrl_bench.sv
module pad_event_ctrl_bench;
  localparam int NP = 24;
  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pad_in = '0, host_own = '1, sysctl_route = '0;
  logic bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, wake;
  int total = 0, fails = 0;
  logic [31:0] d;

  pad_event_ctrl #(.NUM_PADS(NP), .ADDR_W(8)) u_pad_event_ctrl (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .host_own(host_own),
    .sysctl_route(sysctl_route), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic clr_all();
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd(8'h00, d); chk("R1 status", d, 0);
    rd(8'h04, d); chk("R1 enable", d, 0);
    rd(8'h08, d); chk("R1 wake status", d, 0);
    rd(8'h0C, d); chk("R1 wake enable", d, 0);
    rd(8'h10, d); chk("R1 cfg pad0", d, 2);
    rd(8'h6C, d); chk("R1 cfg pad23", d, 2);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
  endtask

  task automatic t_encoding();
    wr(8'h18, 32'h0000_0007); rd(8'h18, d); chk("R11 cfg write 7", d, 7);
    wr(8'h18, 32'hFFFF_FFF9); rd(8'h18, d); chk("R11 upper bits dropped", d, 1);
    wr(8'h18, 32'h2);
  endtask

  task automatic t_level();
    clr_all();
    wr(8'h10, 32'h0); settle();
    rd(8'h00, d); chk("R2 level inactive", d, 0);
    @(negedge clk); pad_in[0] = 1; settle();
    rd(8'h00, d); chk("R2 level high sets", d, 32'h1);
    wr(8'h00, 32'h1); rd(8'h00, d); chk("R6 level persists after clear", d, 32'h1);
    @(negedge clk); pad_in[0] = 0; settle();
    wr(8'h00, 32'h1); rd(8'h00, d); chk("R6 clear after level gone", d, 0);
    wr(8'h10, 32'h2);
    wr(8'h14, 32'h4); settle();
    rd(8'h00, d); chk("R2 inverted level low sets", d, 32'h2);
    @(negedge clk); pad_in[1] = 1; settle();
    wr(8'h00, 32'h2); rd(8'h00, d); chk("R2 inverted level high idle", d, 0);
    wr(8'h14, 32'h2);
  endtask

  task automatic t_edge();
    clr_all();
    wr(8'h18, 32'h1); wr(8'h1C, 32'h5); settle();
    rd(8'h00, d); chk("R3 no event on config", d, 0);
    @(negedge clk); pad_in[2] = 1; pad_in[3] = 1; settle();
    rd(8'h00, d); chk("R3 rising sets only plain pad", d, 32'h4);
    wr(8'h00, 32'hC);
    @(negedge clk); pad_in[2] = 0; pad_in[3] = 0; settle();
    rd(8'h00, d); chk("R3 falling sets only inverted pad", d, 32'h8);
    wr(8'h1C, 32'h2);
  endtask

  task automatic t_both();
    clr_all();
    wr(8'h20, 32'h3);
    @(negedge clk); pad_in[4] = 1; settle();
    rd(8'h00, d); chk("R4 rising", d, 32'h10);
    wr(8'h00, 32'h10); rd(8'h00, d); chk("R6 edge bit cleared", d, 0);
    @(negedge clk); pad_in[4] = 0; settle();
    rd(8'h00, d); chk("R4 falling", d, 32'h10);
  endtask

  task automatic t_disabled();
    clr_all();
    wr(8'h24, 32'h2); wr(8'h28, 32'h6);
    @(negedge clk); pad_in[5] = 1; pad_in[6] = 1; settle();
    @(negedge clk); pad_in[5] = 0; pad_in[6] = 0; settle();
    rd(8'h00, d); chk("R5 disabled pads quiet", d, 0);
  endtask

  task automatic t_irq();
    clr_all();
    wr(8'h00, 32'h0);
    @(negedge clk); pad_in[2] = 1; settle();
    rd(8'h00, d); chk("R7 pending without enable", d, 32'h4);
    chk("R7 irq low when disabled", irq, 0);
    wr(8'h04, 32'h4); #1 chk("R7 irq high when enabled", irq, 1);
    wr(8'h00, 32'h1); rd(8'h00, d); chk("R6 zero bits kept", d, 32'h4);
    wr(8'h04, 32'h0); #1 chk("R7 irq low after disable", irq, 0);
    wr(8'h04, 32'h4); wr(8'h00, 32'h4); #1 chk("R7 irq low after clear", irq, 0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_host();
    clr_all();
    @(negedge clk); host_own[2] = 0; pad_in[2] = 0; settle();
    @(negedge clk); pad_in[2] = 1; settle();
    rd(8'h00, d); chk("R8 unowned pad no status", d, 0);
    rd(8'h08, d); chk("R9 wake status regardless of owner", d, 32'h4);
    @(negedge clk); host_own[2] = 1;
    wr(8'h18, 32'h2);
  endtask

  task automatic t_wake();
    clr_all();
    @(negedge clk); pad_in[4] = 1; settle();
    rd(8'h08, d); chk("R9 wake status set", d, 32'h10);
    chk("R9 wake low without enable", wake, 0);
    wr(8'h0C, 32'h10); #1 chk("R9 wake high", wake, 1);
    @(negedge clk); sysctl_route[4] = 1; #1 chk("R9 routed pad no wake", wake, 0);
    @(negedge clk); sysctl_route[4] = 0; #1 chk("R9 wake back", wake, 1);
    wr(8'h08, 32'h10); #1 chk("R9 wake low after clear", wake, 0);
    rd(8'h08, d); chk("R9 wake status cleared", d, 0);
    wr(8'h0C, 32'h0); wr(8'h20, 32'h2);
  endtask

  task automatic t_tail();
    clr_all();
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R10 enable tail", d, 32'h00FF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R10 wake enable tail", d, 32'h00FF_FFFF);
    wr(8'h70, 32'h3); rd(8'h70, d); chk("R10 cfg beyond last pad", d, 0);
    wr(8'h04, 32'h0); wr(8'h0C, 32'h0);
    @(negedge clk); pad_in[23] = 1; wr(8'h6C, 32'h0); settle();
    rd(8'h00, d); chk("R10 last pad sets, tail clear", d, 32'h0080_0000);
    wr(8'h6C, 32'h2); clr_all();
    rd(8'h00, d); chk("R10 cleared", d, 0);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_encoding();
    t_level();
    t_edge();
    t_both();
    t_disabled();
    t_irq();
    t_host();
    t_wake();
    t_tail();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule